// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces a stream of single-cycle tick pulses at a rate set by one 32-bit configuration word. The word holds a 12-bit integer prescale and a 16-bit fractional step. An integer prescaler first divides the system clock by (scale+1). On every prescaled cycle, the step is added into a 17-bit phase accumulator. Each carry out of that accumulator gives one tick. The resulting average rate is clk/(scale+1) × step/2^17.

The configuration word is a level input. The block keeps a registered copy of the two used fields. Whenever either field differs from that copy, the block restarts its phase from zero, so a retimed baud rate always starts from a clean phase. Bits outside the two fields are ignored. A serial transmitter or receiver uses `tick` as its bit-rate or oversampling strobe.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescale value is taken from `cfg_word[27:16]` and the step from `cfg_word[15:0]`. Any scale from 0 to 4095 is honoured.
- R2: With scale 0 the accumulator advances on every system clock cycle.
- R3: With scale S the accumulator advances exactly once every S+1 clock cycles.
- R4: Each advance adds the step into a 17-bit accumulator, and a carry out of bit 16 raises the tick. Counting advances from a restart, the n-th tick comes on advance m = ceil(n·2^17/step).
- R5: `tick` is high for exactly one cycle per carry and is never high in two consecutive cycles.
- R6: A step of 0 never produces a tick.
- R7: A change of `cfg_word[27:0]` sampled at clock edge E0 restarts the block: the prescaler count and the accumulator are cleared. The tick for advance m is then high in the cycle after edge E0+2+m·(S+1), and no tick from the new word appears earlier.
- R8: Synchronous active-high `rst` drives `tick` low and makes the held configuration all zero. A nonzero word present when reset is released therefore counts as a change under R7.
- R9: Changing only `cfg_word[31:28]` has no effect on the tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word: prescale in [27:16], step in [15:0] |
| tick | output | 1 | Registered single-cycle baud tick |

## Verification
On every cycle, the assertions check the following:
- prescaled advances are spaced whenever scale is nonzero;
- advances are continuous when scale is zero;
- the tick never lasts two cycles;
- a zero step never carries;
- a restart leaves a cleared accumulator;
- reset forces the tick low.

The exact tick positions under the ceiling formula can only be shown by the bench's scenarios. These scenarios compare every tick against the edge predicted from the requirements, including the largest scale, a near-full step and a mid-run reset. The same holds for the phase restart on a new word and for the immunity to the ignored upper bits.

// File: rtl/baud_pkg.sv
package baud_pkg;
  timeunit 1ns;
  timeprecision 100ps;
  localparam int CFG_W     = 32;
  localparam int SCALE_W   = 12;
  localparam int SCALE_LSB = 16;
  localparam int STEP_W    = 16;
  localparam int STEP_LSB  = 0;
endpackage

// File: rtl/baud_cfg_latch.sv
module baud_cfg_latch #(
  parameter int CFG_W     = baud_pkg::CFG_W,
  parameter int SCALE_W   = baud_pkg::SCALE_W,
  parameter int SCALE_LSB = baud_pkg::SCALE_LSB,
  parameter int STEP_W    = baud_pkg::STEP_W,
  parameter int STEP_LSB  = baud_pkg::STEP_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   cfg_word,
  output logic [SCALE_W-1:0] scale_o,
  output logic [STEP_W-1:0]  step_o,
  output logic               restart_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [SCALE_W-1:0] scale_in, scale_q;
  logic [STEP_W-1:0]  step_in, step_q;
  logic               restart_q;
  logic [CFG_W-1:0]   unused_cfg;

  assign scale_in   = cfg_word[SCALE_LSB +: SCALE_W];
  assign step_in    = cfg_word[STEP_LSB +: STEP_W];
  assign unused_cfg = cfg_word;

  // Shadow copy of the used fields; a difference flags a restart one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q   <= '0;
      step_q    <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= ({scale_in, step_in} != {scale_q, step_q});
      scale_q   <= scale_in;
      step_q    <= step_in;
    end
  end

  assign scale_o   = scale_q;
  assign step_o    = step_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SCALE_W = baud_pkg::SCALE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               adv_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [SCALE_W-1:0] cnt_q;
  logic               adv_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else if (cnt_q >= scale_i) begin
      cnt_q <= '0;
      adv_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      adv_q <= 1'b0;
    end
  end

  assign adv_o = adv_q;

  // With a nonzero scale two advances are never adjacent
  assert_adv_spaced_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_q && scale_i != '0) |=> !adv_q);

  // With scale zero and no restart the advance strobe stays on
  assert_every_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (adv_q && scale_i == '0 && !restart_i) |=> adv_q);
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int STEP_W = baud_pkg::STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              tick_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ACC_W = STEP_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  assign sum = {1'b0, acc_q} + {{(ACC_W + 1 - STEP_W){1'b0}}, step_i};

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (adv_i) begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);

  assert_zero_step_R6: assert property (@(posedge clk) disable iff (rst)
    (adv_i && step_i == '0) |=> !tick_q);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (acc_q == '0 && !tick_q));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> !tick_q);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CFG_W     = baud_pkg::CFG_W,
  parameter int SCALE_W   = baud_pkg::SCALE_W,
  parameter int SCALE_LSB = baud_pkg::SCALE_LSB,
  parameter int STEP_W    = baud_pkg::STEP_W,
  parameter int STEP_LSB  = baud_pkg::STEP_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             tick
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [SCALE_W-1:0] scale;
  logic [STEP_W-1:0]  step;
  logic               restart;
  logic               adv;

  baud_cfg_latch #(
    .CFG_W(CFG_W), .SCALE_W(SCALE_W), .SCALE_LSB(SCALE_LSB),
    .STEP_W(STEP_W), .STEP_LSB(STEP_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_word(cfg_word),
    .scale_o(scale), .step_o(step), .restart_o(restart)
  );

  baud_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst(rst), .restart_i(restart), .scale_i(scale), .adv_o(adv)
  );

  baud_phase_acc #(.STEP_W(STEP_W)) u_acc (
    .clk(clk), .rst(rst), .restart_i(restart), .adv_i(adv),
    .step_i(step), .tick_o(tick)
  );
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        tick;

  int    edge_no = 0;
  int    cur_e0 = 0;
  int    q[$];
  int    total = 0;
  int    fails = 0;
  int    unexpected = 0;
  bit    mon_on = 1'b0;
  bit    prev_tick = 1'b0;
  bit    done = 1'b0;
  string tag = "none";

  baud_tick_gen dut (.clk(clk), .rst(rst), .cfg_word(cfg_word), .tick(tick));

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;

  // Monitor: pops expected tick edges from the scoreboard queue
  always @(negedge clk) begin
    if (rst || !mon_on) begin
      prev_tick = 1'b0;
    end else begin
      while (q.size() > 0 && q[0] < edge_no) begin
        total++; fails++;
        $display("FAIL %s (R4): missed tick, actual none, expected tick at edge %0d", tag, q[0]);
        void'(q.pop_front());
      end
      if (tick && edge_no > cur_e0) begin
        total++;
        if (q.size() > 0 && q[0] == edge_no) begin
          void'(q.pop_front());
        end else begin
          fails++; unexpected++;
          $display("FAIL %s (R4/R7): tick at edge %0d, expected edge %0d", tag, edge_no,
                   (q.size() > 0) ? q[0] : -1);
        end
      end
      if (tick) begin
        total++;
        if (prev_tick) begin
          fails++;
          $display("FAIL %s (R5): tick high two cycles, actual 1, expected 0", tag);
        end
      end
      prev_tick = tick;
    end
  end

  // Driver: predicts tick edges from the rate formula and waits the window
  task automatic expect_window(input int scale, input int step, input int win,
                               input string t, input int bump_at, input logic [31:0] bump_word);
    longint n, m, e;
    tag = t; cur_e0 = edge_no + 1; unexpected = 0; q.delete();
    if (step != 0) begin
      n = 1;
      while (1) begin
        m = (n * 131072 + step - 1) / step;
        e = cur_e0 + 2 + m * (scale + 1);
        if (e > cur_e0 + win) break;
        q.push_back(int'(e));
        n++;
      end
    end
    mon_on = 1'b1;
    while (edge_no < cur_e0 + win) begin
      @(negedge clk);
      if (bump_at > 0 && edge_no == cur_e0 + bump_at) cfg_word = bump_word;
    end
    #1;
    total++;
    if (q.size() != 0 || unexpected != 0) begin
      fails++;
      $display("FAIL %s: window end, actual leftover %0d unexpected %0d, expected 0 0",
               t, q.size(), unexpected);
    end
    mon_on = 1'b0;
  endtask

  task automatic apply(input logic [31:0] w, input int win, input string t);
    cfg_word = w;
    expect_window(int'(w[27:16]), int'(w[15:0]), win, t, 0, 32'h0);
  endtask

  task automatic check_low(input string t);
    total++;
    if (tick !== 1'b0) begin
      fails++;
      $display("FAIL %s: tick during reset, actual %b, expected 0", t, tick);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_low("R8 reset state");
    rst = 1'b0;
    expect_window(0, 0, 50, "R8 idle zero config", 0, 32'h0);
    apply(32'h0000_8000, 40, "R2 R7 scale0 half step");
    apply(32'h0000_FFFF, 60, "R2 R5 scale0 near-full step");
    apply(32'h0002_1234, 3000, "R3 R4 scale2 odd step");
    apply(32'h0FFF_FFFF, 25000, "R1 R3 max scale");
    apply(32'h0000_0000, 300, "R6 zero step");
    apply(32'h3000_0000, 300, "R6 R9 zero step upper bits");
    cfg_word = 32'h0001_5555;
    expect_window(1, 'h5555, 400, "R9 R1 upper bits toggled", 123, 32'hF001_5555);
    apply(32'h0001_C000, 100, "R7 retime mid-run");
    @(negedge clk);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_low("R8 reset mid-run");
    end
    rst = 1'b0;
    expect_window(1, 'hC000, 200, "R8 R7 restart after reset", 0, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, actual running, expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule